// File: doc/BRIEF.md
# Page Access Permission Checker

This block rules on a single memory access once an address translation has completed. It receives the rights gathered along the walk (user-accessible, writable, no-execute), the kind of access (instruction fetch, user mode, write, implicit supervisor access), the mode enables (no-execute, supervisor execution prevention, supervisor access prevention, write protection, user and supervisor protection keys), the alignment-check flag, the protection key of the leaf entry, and two key-rights registers. It returns a single allow/deny verdict together with the fault-code bits that a fault handler would need.

The decision is combinational. It is captured in a register one cycle after a request is strobed. The protection-key check, the no-execute check, the user-mode checks and the supervisor-mode checks are combined into one verdict. An input combination that no real access can produce (an implicit access marked as a fetch or as user mode) raises a separate error flag. The page walk itself and the delivery of the fault are handled elsewhere.

Top module: `pg_access_check`

## Requirements
- R1: The result is registered. One cycle after `req_valid` is high, `res_valid` is high and `allow`, `fault_code` and `illegal_combo` reflect that request. In a cycle after `req_valid` was low, `res_valid` is low and `allow`, `fault_code` and `illegal_combo` keep their values. Reset clears all outputs to 0.
- R2: `fault_code` bit 0 equals the write flag and bit 1 equals the user-mode flag, always. Bit 2 equals the fetch flag only when `en_nx` or `en_smep` is set, and is 0 otherwise. Bit 3 is the protection-key fault bit.
- R3: An instruction fetch from a page whose no-execute right is set is denied.
- R4: A user-mode access to a page without the user right is denied. A user-mode write to a page without the writable right is denied.
- R5: A supervisor instruction fetch from a user page is denied when `en_smep` is set, and is allowed when `en_smep` is clear.
- R6: A supervisor data access to a user page is denied when `en_smap` is set, unless `ac_flag` is set and the access is not implicit. Fetches are not subject to this check.
- R7: A supervisor write to a page without the writable right is denied only when `en_wp` is set.
- R8: The key check applies to data accesses only, never to fetches. A user page uses `ukey_rights` when `en_ukey` is set. A supervisor page uses `skey_rights` when `en_skey` is set. Key k owns bits [2k+1:2k] of the register: bit 2k is access-disable and bit 2k+1 is write-disable.
- R9: A set access-disable bit for the selected key denies the access and sets `fault_code` bit 3.
- R10: A set write-disable bit for the selected key denies a write when the access is in user mode or `en_wp` is set, and then sets `fault_code` bit 3. A read is not affected by it.
- R11: `illegal_combo` is high for a request whose implicit flag is set together with the fetch or the user-mode flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Strobe: evaluate this cycle's inputs |
| rights_user | input | 1 | Accumulated user-accessible right |
| rights_write | input | 1 | Accumulated writable right |
| rights_nx | input | 1 | Accumulated no-execute bit |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_user | input | 1 | Access is in user mode |
| acc_write | input | 1 | Access is a write |
| acc_implicit | input | 1 | Access is an implicit supervisor access |
| en_nx | input | 1 | No-execute enabled |
| en_smep | input | 1 | Supervisor execution prevention enabled |
| en_smap | input | 1 | Supervisor access prevention enabled |
| en_wp | input | 1 | Supervisor write protection enabled |
| en_ukey | input | 1 | User-page protection keys enabled |
| en_skey | input | 1 | Supervisor-page protection keys enabled |
| ac_flag | input | 1 | Alignment-check flag (supervisor access prevention override) |
| leaf_key | input | KEY_W | Protection key of the leaf entry |
| ukey_rights | input | 2*2^KEY_W | User key-rights register |
| skey_rights | input | 2*2^KEY_W | Supervisor key-rights register |
| res_valid | output | 1 | Registered result is valid |
| allow | output | 1 | Access permitted |
| fault_code | output | 4 | {key, fetch, user, write} fault bits |
| illegal_combo | output | 1 | Impossible access-type combination seen |

## Verification
The check table crosses page rights with each access kind: user reads and writes, user and supervisor fetches, supervisor reads and writes. These cases separate the user-mode, no-execute, execution-prevention, access-prevention and write-protect rules from one another. Paired rows differ in one enable or flag, for example the alignment override with and without the implicit flag, or a read-only write with and without write protection, so that each rule is shown to depend on exactly its own condition. Directed key cases place rights on the selected key and on its neighbour. They also swap the user and supervisor registers and turn a fetch into a data access, which shows that key selection, field position and the data-only rule are all honoured.

// File: rtl/pg_access_pkg.sv
package pg_access_pkg;

  localparam int FC_W     = 4;
  localparam int FB_WRITE = 0;
  localparam int FB_USER  = 1;
  localparam int FB_FETCH = 2;
  localparam int FB_KEY   = 3;

  localparam int KF_AD = 0;
  localparam int KF_WD = 1;

  typedef struct packed {
    logic            allow;
    logic [FC_W-1:0] fault;
    logic            illegal;
  } verdict_t;

  function automatic logic fetch_reported(input logic nx_on, input logic smep_on);
    return nx_on | smep_on;
  endfunction

  function automatic logic wd_applies(input logic is_write, input logic is_user,
                                      input logic wp_on);
    return is_write & (is_user | wp_on);
  endfunction

  function automatic logic smap_override(input logic ac, input logic implicit_acc);
    return ac & ~implicit_acc;
  endfunction

  function automatic logic combo_illegal(input logic implicit_acc, input logic fetch,
                                         input logic user);
    return implicit_acc & (fetch | user);
  endfunction

endpackage

// File: rtl/pg_key_eval.sv
module pg_key_eval
  import pg_access_pkg::*;
#(
  parameter  int KEY_W  = 4,
  localparam int NKEYS  = 1 << KEY_W,
  localparam int KREG_W = 2 * NKEYS
) (
  input  logic              page_user,
  input  logic              acc_fetch,
  input  logic              acc_user,
  input  logic              acc_write,
  input  logic              en_ukey,
  input  logic              en_skey,
  input  logic              en_wp,
  input  logic [KEY_W-1:0]  leaf_key,
  input  logic [KREG_W-1:0] ukey_rights,
  input  logic [KREG_W-1:0] skey_rights,
  output logic              key_deny
);

  logic [1:0] ufld [NKEYS];
  logic [1:0] sfld [NKEYS];

  for (genvar g = 0; g < NKEYS; g++) begin : g_fld
    assign ufld[g] = ukey_rights[2*g +: 2];
    assign sfld[g] = skey_rights[2*g +: 2];
  end

  logic       key_on;
  logic [1:0] sel;
  logic       ad_hit;
  logic       wd_hit;

  assign key_on   = ~acc_fetch & (page_user ? en_ukey : en_skey);
  assign sel      = page_user ? ufld[leaf_key] : sfld[leaf_key];
  assign ad_hit   = key_on & sel[KF_AD];
  assign wd_hit   = key_on & sel[KF_WD] & wd_applies(acc_write, acc_user, en_wp);
  assign key_deny = ad_hit | wd_hit;

endmodule

// File: rtl/pg_priv_eval.sv
module pg_priv_eval
  import pg_access_pkg::*;
(
  input  logic rights_user,
  input  logic rights_write,
  input  logic rights_nx,
  input  logic acc_fetch,
  input  logic acc_user,
  input  logic acc_write,
  input  logic acc_implicit,
  input  logic en_smep,
  input  logic en_smap,
  input  logic en_wp,
  input  logic ac_flag,
  output logic priv_deny
);

  logic nx_deny;
  logic um_deny;
  logic smep_deny;
  logic smap_deny;
  logic wp_deny;
  logic sup_on_user;

  assign nx_deny     = acc_fetch & rights_nx;
  assign um_deny     = acc_user & (~rights_user | (acc_write & ~rights_write));
  assign sup_on_user = ~acc_user & rights_user;
  assign smep_deny   = sup_on_user & acc_fetch & en_smep;
  assign smap_deny   = sup_on_user & ~acc_fetch & en_smap &
                       ~smap_override(ac_flag, acc_implicit);
  assign wp_deny     = ~acc_user & acc_write & ~rights_write & en_wp;

  assign priv_deny = nx_deny | um_deny | smep_deny | smap_deny | wp_deny;

endmodule

// File: rtl/pg_fault_fmt.sv
module pg_fault_fmt
  import pg_access_pkg::*;
(
  input  logic            acc_fetch,
  input  logic            acc_user,
  input  logic            acc_write,
  input  logic            en_nx,
  input  logic            en_smep,
  input  logic            key_deny,
  output logic [FC_W-1:0] fault_code
);

  always_comb begin
    fault_code           = '0;
    fault_code[FB_WRITE] = acc_write;
    fault_code[FB_USER]  = acc_user;
    fault_code[FB_FETCH] = acc_fetch & fetch_reported(en_nx, en_smep);
    fault_code[FB_KEY]   = key_deny;
  end

endmodule

// File: rtl/pg_access_check.sv
module pg_access_check
  import pg_access_pkg::*;
#(
  parameter  int KEY_W  = 4,
  localparam int KREG_W = 2 * (1 << KEY_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              rights_user,
  input  logic              rights_write,
  input  logic              rights_nx,
  input  logic              acc_fetch,
  input  logic              acc_user,
  input  logic              acc_write,
  input  logic              acc_implicit,
  input  logic              en_nx,
  input  logic              en_smep,
  input  logic              en_smap,
  input  logic              en_wp,
  input  logic              en_ukey,
  input  logic              en_skey,
  input  logic              ac_flag,
  input  logic [KEY_W-1:0]  leaf_key,
  input  logic [KREG_W-1:0] ukey_rights,
  input  logic [KREG_W-1:0] skey_rights,
  output logic              res_valid,
  output logic              allow,
  output logic [FC_W-1:0]   fault_code,
  output logic              illegal_combo
);

  logic            key_deny;
  logic            priv_deny;
  logic [FC_W-1:0] fault_c;
  verdict_t        next_v;
  verdict_t        cur_v;

  pg_key_eval #(.KEY_W(KEY_W)) u_key (
    .page_user   (rights_user),
    .acc_fetch   (acc_fetch),
    .acc_user    (acc_user),
    .acc_write   (acc_write),
    .en_ukey     (en_ukey),
    .en_skey     (en_skey),
    .en_wp       (en_wp),
    .leaf_key    (leaf_key),
    .ukey_rights (ukey_rights),
    .skey_rights (skey_rights),
    .key_deny    (key_deny)
  );

  pg_priv_eval u_priv (
    .rights_user  (rights_user),
    .rights_write (rights_write),
    .rights_nx    (rights_nx),
    .acc_fetch    (acc_fetch),
    .acc_user     (acc_user),
    .acc_write    (acc_write),
    .acc_implicit (acc_implicit),
    .en_smep      (en_smep),
    .en_smap      (en_smap),
    .en_wp        (en_wp),
    .ac_flag      (ac_flag),
    .priv_deny    (priv_deny)
  );

  pg_fault_fmt u_fmt (
    .acc_fetch  (acc_fetch),
    .acc_user   (acc_user),
    .acc_write  (acc_write),
    .en_nx      (en_nx),
    .en_smep    (en_smep),
    .key_deny   (key_deny),
    .fault_code (fault_c)
  );

  always_comb begin
    next_v.allow   = ~key_deny & ~priv_deny;
    next_v.fault   = fault_c;
    next_v.illegal = combo_illegal(acc_implicit, acc_fetch, acc_user);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      cur_v     <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) cur_v <= next_v;
    end
  end

  assign allow         = cur_v.allow;
  assign fault_code    = cur_v.fault;
  assign illegal_combo = cur_v.illegal;

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(allow) && $stable(fault_code));
  a_r2_fetch_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !en_nx && !en_smep |=> !fault_code[FB_FETCH]);
  a_r2_user_bit: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> fault_code[FB_USER] == $past(acc_user));
  a_r3_nx_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && acc_fetch && rights_nx |=> !allow);
  a_r4_sup_page: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && acc_user && !rights_user |=> !allow);
  a_r8_no_key_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && acc_fetch |=> !fault_code[FB_KEY]);
  a_r9_key_denies: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && fault_code[FB_KEY] |-> !allow);
  a_r11_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && acc_implicit && (acc_fetch || acc_user) |=> illegal_combo);

endmodule

// File: tb/sim_pg_access_check.sv
`timescale 1ns/1ps
module sim_pg_access_check;

  localparam int KEY_W  = 4;
  localparam int KREG_W = 2 * (1 << KEY_W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic rights_user = 1'b0, rights_write = 1'b0, rights_nx = 1'b0;
  logic acc_fetch = 1'b0, acc_user = 1'b0, acc_write = 1'b0, acc_implicit = 1'b0;
  logic en_nx = 1'b0, en_smep = 1'b0, en_smap = 1'b0, en_wp = 1'b0;
  logic en_ukey = 1'b0, en_skey = 1'b0, ac_flag = 1'b0;
  logic [KEY_W-1:0]  leaf_key = '0;
  logic [KREG_W-1:0] ukey_rights = '0, skey_rights = '0;
  logic              res_valid, allow, illegal_combo;
  logic [3:0]        fault_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pg_access_check #(.KEY_W(KEY_W)) u0 (
    .clk, .rst_n, .req_valid, .rights_user, .rights_write, .rights_nx,
    .acc_fetch, .acc_user, .acc_write, .acc_implicit, .en_nx, .en_smep,
    .en_smap, .en_wp, .en_ukey, .en_skey, .ac_flag, .leaf_key,
    .ukey_rights, .skey_rights, .res_valid, .allow, .fault_code, .illegal_combo
  );

  // {exp_allow | ru rw rnx | fetch user write implicit | nx smep smap wp ukey skey | ac}
  localparam logic [14:0] VEC [16] = '{
    {1'b1, 3'b100, 4'b0100, 6'b000000, 1'b0},  // R4 user read of user page
    {1'b0, 3'b010, 4'b0100, 6'b000000, 1'b0},  // R4 user read of supervisor page
    {1'b0, 3'b100, 4'b0110, 6'b000000, 1'b0},  // R4 user write to read-only page
    {1'b1, 3'b110, 4'b0110, 6'b000000, 1'b0},  // R4 user write to writable page
    {1'b0, 3'b101, 4'b1100, 6'b100000, 1'b0},  // R3 fetch from no-execute page
    {1'b1, 3'b100, 4'b1100, 6'b100000, 1'b0},  // R3 fetch from executable page
    {1'b0, 3'b100, 4'b1000, 6'b010000, 1'b0},  // R5 supervisor fetch, smep on
    {1'b1, 3'b100, 4'b1000, 6'b000000, 1'b0},  // R5 supervisor fetch, smep off
    {1'b0, 3'b100, 4'b0000, 6'b001000, 1'b0},  // R6 supervisor read, smap on
    {1'b1, 3'b100, 4'b0000, 6'b001000, 1'b1},  // R6 override by ac flag
    {1'b0, 3'b100, 4'b0001, 6'b001000, 1'b1},  // R6 implicit ignores override
    {1'b1, 3'b100, 4'b1000, 6'b001000, 1'b0},  // R6 fetch not subject to smap
    {1'b1, 3'b000, 4'b0010, 6'b000000, 1'b0},  // R7 read-only write, wp off
    {1'b0, 3'b000, 4'b0010, 6'b000100, 1'b0},  // R7 read-only write, wp on
    {1'b1, 3'b100, 4'b0010, 6'b000000, 1'b0},  // R7 user page write, wp off
    {1'b1, 3'b010, 4'b0000, 6'b111100, 1'b0}   // R7 supervisor read, all on
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    {rights_user, rights_write, rights_nx} = 3'b000;
    {acc_fetch, acc_user, acc_write, acc_implicit} = 4'b0000;
    {en_nx, en_smep, en_smap, en_wp, en_ukey, en_skey, ac_flag} = 7'b0;
    leaf_key = '0; ukey_rights = '0; skey_rights = '0;
  endtask

  task automatic fire();
    @(negedge clk) req_valid = 1'b1;
    @(negedge clk) req_valid = 1'b0;
  endtask

  function automatic logic [3:0] exp_fault(input logic key_bit);
    return {key_bit, acc_fetch & (en_nx | en_smep), acc_user, acc_write};
  endfunction

  task automatic fire_check(input string tag, input logic ea, input logic ekey,
                            input logic eill);
    fire();
    check({tag, " res_valid"}, {7'b0, res_valid}, 8'd1);
    check({tag, " allow"}, {7'b0, allow}, {7'b0, ea});
    check({tag, " fault_code"}, {4'b0, fault_code}, {4'b0, exp_fault(ekey)});
    check({tag, " illegal"}, {7'b0, illegal_combo}, {7'b0, eill});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset res_valid", {7'b0, res_valid}, 8'd0);
    check("R1 reset allow", {7'b0, allow}, 8'd0);
    check("R1 reset fault_code", {4'b0, fault_code}, 8'd0);
    check("R1 reset illegal", {7'b0, illegal_combo}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 16; i++) begin
      clear_inputs();
      {rights_user, rights_write, rights_nx} = VEC[i][13:11];
      {acc_fetch, acc_user, acc_write, acc_implicit} = VEC[i][10:7];
      {en_nx, en_smep, en_smap, en_wp, en_ukey, en_skey} = VEC[i][6:1];
      ac_flag = VEC[i][0];
      fire_check($sformatf("R2 table row %0d", i), VEC[i][14], 1'b0, 1'b0);
    end

    // R2: fetch bit hidden with neither nx nor smep
    clear_inputs(); rights_user = 1'b1; acc_fetch = 1'b1; acc_user = 1'b1;
    fire_check("R2 fetch bit hidden", 1'b1, 1'b0, 1'b0);

    // R1: hold when no request
    clear_inputs(); rights_user = 1'b0; acc_user = 1'b1;
    fire_check("R1 deny before hold", 1'b0, 1'b0, 1'b0);
    rights_user = 1'b1; acc_write = 1'b1; rights_write = 1'b1;
    @(negedge clk);
    check("R1 idle res_valid", {7'b0, res_valid}, 8'd0);
    check("R1 idle allow held", {7'b0, allow}, 8'd0);
    check("R1 idle fault held", {4'b0, fault_code}, 8'h2);

    // R9: access-disable on user key 5 (bit 10)
    clear_inputs(); rights_user = 1'b1; acc_user = 1'b1; en_ukey = 1'b1;
    leaf_key = 4'd5; ukey_rights[10] = 1'b1;
    fire_check("R9 access-disable", 1'b0, 1'b1, 1'b0);
    en_ukey = 1'b0;
    fire_check("R8 user keys disabled", 1'b1, 1'b0, 1'b0);
    en_ukey = 1'b1; leaf_key = 4'd4;
    fire_check("R8 neighbour key field", 1'b1, 1'b0, 1'b0);
    leaf_key = 4'd5; acc_fetch = 1'b1; en_nx = 1'b1;
    fire_check("R8 fetch skips keys", 1'b1, 1'b0, 1'b0);
    // supervisor page consults the supervisor register
    clear_inputs(); en_ukey = 1'b1; en_skey = 1'b1; leaf_key = 4'd5;
    ukey_rights[10] = 1'b1;
    fire_check("R8 supervisor page uses skey", 1'b1, 1'b0, 1'b0);
    skey_rights[10] = 1'b1;
    fire_check("R8 R9 supervisor key access-disable", 1'b0, 1'b1, 1'b0);

    // R10: write-disable on key 2 (bit 5)
    clear_inputs(); rights_user = 1'b1; rights_write = 1'b1; acc_user = 1'b1;
    acc_write = 1'b1; en_ukey = 1'b1; leaf_key = 4'd2; ukey_rights[5] = 1'b1;
    fire_check("R10 user write-disable", 1'b0, 1'b1, 1'b0);
    acc_write = 1'b0;
    fire_check("R10 read unaffected", 1'b1, 1'b0, 1'b0);
    clear_inputs(); rights_write = 1'b1; acc_write = 1'b1; en_skey = 1'b1;
    leaf_key = 4'd2; skey_rights[5] = 1'b1;
    fire_check("R10 supervisor write, wp off", 1'b1, 1'b0, 1'b0);
    en_wp = 1'b1;
    fire_check("R10 supervisor write, wp on", 1'b0, 1'b1, 1'b0);

    // R11: illegal combinations
    clear_inputs(); acc_implicit = 1'b1; acc_fetch = 1'b1; en_nx = 1'b1;
    fire_check("R11 implicit fetch", 1'b1, 1'b0, 1'b1);
    clear_inputs(); acc_implicit = 1'b1; acc_user = 1'b1; rights_user = 1'b1;
    fire_check("R11 implicit user", 1'b1, 1'b0, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule